// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches one bank of general-purpose input pins and raises a latched status bit for every pin on which an interrupt condition is seen. The status bits, gated by a per-pin mask, are ORed into a single bank interrupt line. Out of reset every pin reports any change, rising or falling. A pin whose extended detection is switched on instead uses its own settings: edge or level, and high/rising or low/falling.

Software configures the block through a one-cycle command port. Each command carries an operation code and a pin mask, and affects only the pins whose mask bit is set. This gives set/clear semantics without any read-modify-write. The current status is always visible on `status_o`. Pulsing the read strobe acknowledges it, so that status bits are cleared on the next edge. Pin inputs first pass through a synchronizer. Edges are found by comparing the synchronized value with its copy from one cycle earlier.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is held, `status_o`, `irq_mask_o`, `mode_en_o`, `level_sel_o` and `pol_high_o` are all zero and `irq_o` is low.
- R2: When a pin's extended detection is off, a rising or a falling change on the pin sets its status bit. The bit is first visible after the third rising clock edge that follows the change, and not after the second.
- R3: Command codes act only on the pins set in `cmd_mask_i`, at the edge where `cmd_valid_i` is high. The codes are: 0 sets the interrupt mask, 1 clears it, 2 turns extended detection on, 3 turns it off, 4 selects edge detection, 5 selects level detection, 6 selects falling/low polarity, and 7 selects rising/high polarity. Each setting reads back on its own output, with 1 meaning enabled, level or rising/high.
- R4: With extended detection on, edge type and rising polarity, only a rising change sets the status bit.
- R5: With extended detection on, edge type and falling polarity, only a falling change sets the status bit.
- R6: With extended detection on, level type and high polarity, the status bit is set while the pin is high, and it reads 1 again right after a read while the pin stays high.
- R7: With extended detection on, level type and low polarity, the status bit is set while the pin is low.
- R8: A read strobe clears every status bit at the next edge, except bits whose condition is present in that cycle.
- R9: An edge detected in the same cycle as a read strobe leaves its status bit set.
- R10: `irq_o` is high exactly when some bit is set in both `status_o` and `irq_mask_o`. Status is still recorded for masked pins.
- R11: Without a read strobe, a set status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| pin_i | input | NUM_PINS | Raw, asynchronous pin levels |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command operation code |
| cmd_mask_i | input | NUM_PINS | Pins affected by the command |
| stat_rd_i | input | 1 | Status read/acknowledge strobe |
| status_o | output | NUM_PINS | Latched interrupt status |
| irq_mask_o | output | NUM_PINS | Interrupt mask readback |
| mode_en_o | output | NUM_PINS | Extended-detection enable readback |
| level_sel_o | output | NUM_PINS | Detection type readback (1 = level) |
| pol_high_o | output | NUM_PINS | Polarity readback (1 = rising/high) |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
The bench builds the block with its defaults: 32 pins and a two-stage synchronizer. With those values the full mask width is exercised by the set/clear table, and the edge latency has one fixed count to check against. Separate pins each carry one detection mode, so all five modes live together in the same bank. This shows that one pin's settings never leak into another pin's status. The coincident edge-and-read case is aimed at the single cycle in which the detector output is high.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
    typedef enum logic [2:0] {
        OP_IRQ_ON    = 3'd0,
        OP_IRQ_OFF   = 3'd1,
        OP_MODE_ON   = 3'd2,
        OP_MODE_OFF  = 3'd3,
        OP_SEL_EDGE  = 3'd4,
        OP_SEL_LEVEL = 3'd5,
        OP_POL_LOW   = 3'd6,
        OP_POL_HIGH  = 3'd7
    } cmd_op_e;
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
// Synchronizer chain plus a one-cycle delayed copy for edge detection.
module gpio_irq_sync #(
    parameter int NUM_PINS = 32,
    parameter int STAGES   = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] pin_cur_o,
    output logic [NUM_PINS-1:0] pin_prev_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][NUM_PINS-1:0] chain;
        logic [NUM_PINS-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pin_cur_o  = st_q.chain[LAST];
    assign pin_prev_o = st_q.prev;
endmodule

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
// Per-pin configuration held in set/clear style registers.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cmd_valid_i,
    input  cmd_op_e             cmd_op_i,
    input  logic [NUM_PINS-1:0] cmd_mask_i,
    output logic [NUM_PINS-1:0] irq_mask_o,
    output logic [NUM_PINS-1:0] mode_en_o,
    output logic [NUM_PINS-1:0] level_sel_o,
    output logic [NUM_PINS-1:0] pol_high_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] irq_mask;
        logic [NUM_PINS-1:0] mode_en;
        logic [NUM_PINS-1:0] level_sel;
        logic [NUM_PINS-1:0] pol_high;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cmd_valid_i) begin
            unique case (cmd_op_i)
                OP_IRQ_ON:    cfg_d.irq_mask  = cfg_q.irq_mask  |  cmd_mask_i;
                OP_IRQ_OFF:   cfg_d.irq_mask  = cfg_q.irq_mask  & ~cmd_mask_i;
                OP_MODE_ON:   cfg_d.mode_en   = cfg_q.mode_en   |  cmd_mask_i;
                OP_MODE_OFF:  cfg_d.mode_en   = cfg_q.mode_en   & ~cmd_mask_i;
                OP_SEL_EDGE:  cfg_d.level_sel = cfg_q.level_sel & ~cmd_mask_i;
                OP_SEL_LEVEL: cfg_d.level_sel = cfg_q.level_sel |  cmd_mask_i;
                OP_POL_LOW:   cfg_d.pol_high  = cfg_q.pol_high  & ~cmd_mask_i;
                OP_POL_HIGH:  cfg_d.pol_high  = cfg_q.pol_high  |  cmd_mask_i;
                default:      cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign irq_mask_o  = cfg_q.irq_mask;
    assign mode_en_o   = cfg_q.mode_en;
    assign level_sel_o = cfg_q.level_sel;
    assign pol_high_o  = cfg_q.pol_high;
endmodule

// File: rtl/gpio_irq_event.sv
`timescale 1ns/1ps
// Per-pin condition detector (purely combinational).
module gpio_irq_event #(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] pin_cur_i,
    input  logic [NUM_PINS-1:0] pin_prev_i,
    input  logic [NUM_PINS-1:0] mode_en_i,
    input  logic [NUM_PINS-1:0] level_sel_i,
    input  logic [NUM_PINS-1:0] pol_high_i,
    output logic [NUM_PINS-1:0] event_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rise, fall, lvl_hit, edge_hit;
        always_comb begin
            rise     = pin_cur_i[p] & ~pin_prev_i[p];
            fall     = ~pin_cur_i[p] & pin_prev_i[p];
            lvl_hit  = (pin_cur_i[p] == pol_high_i[p]);
            edge_hit = pol_high_i[p] ? rise : fall;
            if (!mode_en_i[p])       event_o[p] = rise | fall;
            else if (level_sel_i[p]) event_o[p] = lvl_hit;
            else                     event_o[p] = edge_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                cmd_valid_i,
    input  logic [2:0]          cmd_op_i,
    input  logic [NUM_PINS-1:0] cmd_mask_i,
    input  logic                stat_rd_i,
    output logic [NUM_PINS-1:0] status_o,
    output logic [NUM_PINS-1:0] irq_mask_o,
    output logic [NUM_PINS-1:0] mode_en_o,
    output logic [NUM_PINS-1:0] level_sel_o,
    output logic [NUM_PINS-1:0] pol_high_o,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] pin_cur, pin_prev, pin_event;

    typedef struct packed {
        logic [NUM_PINS-1:0] status;
    } stat_t;

    stat_t st_d, st_q;

    gpio_irq_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pin_i),
        .pin_cur_o  (pin_cur),
        .pin_prev_o (pin_prev)
    );

    gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_e'(cmd_op_i)),
        .cmd_mask_i  (cmd_mask_i),
        .irq_mask_o  (irq_mask_o),
        .mode_en_o   (mode_en_o),
        .level_sel_o (level_sel_o),
        .pol_high_o  (pol_high_o)
    );

    gpio_irq_event #(.NUM_PINS(NUM_PINS)) u_event (
        .pin_cur_i   (pin_cur),
        .pin_prev_i  (pin_prev),
        .mode_en_i   (mode_en_o),
        .level_sel_i (level_sel_o),
        .pol_high_i  (pol_high_o),
        .event_o     (pin_event)
    );

    // A read acknowledges the old status; a condition present now survives it.
    always_comb begin
        st_d        = st_q;
        st_d.status = (stat_rd_i ? '0 : st_q.status) | pin_event;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = |(st_q.status & irq_mask_o);
endmodule

// File: rtl/gpio_irq_detect_chk.sv
`timescale 1ns/1ps
module gpio_irq_detect_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                cmd_valid_i,
    input logic [2:0]          cmd_op_i,
    input logic [NUM_PINS-1:0] cmd_mask_i,
    input logic                stat_rd_i,
    input logic [NUM_PINS-1:0] status_o,
    input logic [NUM_PINS-1:0] irq_mask_o,
    input logic [NUM_PINS-1:0] mode_en_o,
    input logic                irq_o
);
    assert_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_rd_i |=> (($past(status_o) & ~status_o) == '0));

    assert_mask_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == 3'd0) |=>
        ((irq_mask_o & $past(cmd_mask_i)) == $past(cmd_mask_i)));

    assert_mask_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == 3'd1) |=>
        ((irq_mask_o & $past(cmd_mask_i)) == '0));

    assert_mode_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == 3'd2) |=>
        ((mode_en_o & $past(cmd_mask_i)) == $past(cmd_mask_i)));

    assert_irq_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_op_i == 3'd1 && (&cmd_mask_i)) |=> !irq_o);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_mask_i  (cmd_mask_i),
    .stat_rd_i   (stat_rd_i),
    .status_o    (status_o),
    .irq_mask_o  (irq_mask_o),
    .mode_en_o   (mode_en_o),
    .irq_o       (irq_o)
);

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = '0;
    logic [N-1:0] cmd_mask = '0;
    logic         stat_rd = 1'b0;
    logic [N-1:0] status, irq_mask, mode_en, level_sel, pol_high;
    logic         irq;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    gpio_irq_detect #(.NUM_PINS(N), .SYNC_STAGES(2)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_mask_i  (cmd_mask),
        .stat_rd_i   (stat_rd),
        .status_o    (status),
        .irq_mask_o  (irq_mask),
        .mode_en_o   (mode_en),
        .level_sel_o (level_sel),
        .pol_high_o  (pol_high),
        .irq_o       (irq)
    );

    // op, data, expected readback of the register group the op touches
    localparam logic [66:0] VEC_TBL [0:9] = '{
        {3'd0, 32'hFFFF_0000, 32'hFFFF_0000},
        {3'd1, 32'h0F00_0000, 32'hF0FF_0000},
        {3'd0, 32'h0000_000F, 32'hF0FF_000F},
        {3'd2, 32'h0000_00F0, 32'h0000_00F0},
        {3'd2, 32'h0000_0F00, 32'h0000_0FF0},
        {3'd3, 32'h0000_0030, 32'h0000_0FC0},
        {3'd5, 32'h0000_FF00, 32'h0000_FF00},
        {3'd4, 32'h0000_3000, 32'h0000_CF00},
        {3'd7, 32'h0000_00FF, 32'h0000_00FF},
        {3'd6, 32'h0000_000F, 32'h0000_00F0}
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [N-1:0] m);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_mask  = m;
        step(1);
        cmd_valid = 1'b0;
        cmd_mask  = '0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        check("R1 status", status, '0);
        check("R1 mask", irq_mask, '0);
        check("R1 mode", mode_en, '0);
        check("R1 level", level_sel, '0);
        check("R1 pol", pol_high, '0);
        check("R1 irq", {31'b0, irq}, '0);
        rst_n = 1'b1;
        step(1);

        // R3 set/clear table
        for (int i = 0; i < 10; i++) begin
            logic [2:0]   op;
            logic [N-1:0] rb;
            op = VEC_TBL[i][66:64];
            cmd(op, VEC_TBL[i][63:32]);
            case (op[2:1])
                2'd0: rb = irq_mask;
                2'd1: rb = mode_en;
                2'd2: rb = level_sel;
                default: rb = pol_high;
            endcase
            check("R3 table", rb, VEC_TBL[i][31:0]);
        end

        cmd(3'd1, '1);
        cmd(3'd3, '1);
        cmd(3'd4, '1);
        cmd(3'd6, '1);
        do_read();
        check("R8 clean", status, '0);

        // R2 default both-edge with latency
        pins[0] = 1'b1;
        step(2);
        check("R2 latency", {31'b0, status[0]}, 32'd0);
        step(1);
        check("R2 rise", {31'b0, status[0]}, 32'd1);
        do_read();
        check("R8 cleared", status, '0);
        pins[0] = 1'b0;
        step(3);
        check("R2 fall", {31'b0, status[0]}, 32'd1);
        do_read();

        // R4 rising edge only
        cmd(3'd7, 32'h2);
        cmd(3'd2, 32'h2);
        pins[1] = 1'b1;
        step(3);
        check("R4 rise", {31'b0, status[1]}, 32'd1);
        do_read();
        pins[1] = 1'b0;
        step(4);
        check("R4 fall ignored", {31'b0, status[1]}, 32'd0);

        // R5 falling edge only
        cmd(3'd2, 32'h4);
        pins[2] = 1'b1;
        step(4);
        check("R5 rise ignored", {31'b0, status[2]}, 32'd0);
        pins[2] = 1'b0;
        step(3);
        check("R5 fall", {31'b0, status[2]}, 32'd1);
        do_read();

        // R6 high level
        cmd(3'd5, 32'h8);
        cmd(3'd7, 32'h8);
        cmd(3'd2, 32'h8);
        step(3);
        check("R6 inactive", {31'b0, status[3]}, 32'd0);
        pins[3] = 1'b1;
        step(3);
        check("R6 high", {31'b0, status[3]}, 32'd1);
        do_read();
        check("R6 reasserted", {31'b0, status[3]}, 32'd1);
        pins[3] = 1'b0;
        step(4);
        do_read();
        check("R6 released", {31'b0, status[3]}, 32'd0);
        step(2);
        check("R6 stays clear", {31'b0, status[3]}, 32'd0);

        // R7 low level
        cmd(3'd5, 32'h10);
        cmd(3'd6, 32'h10);
        cmd(3'd2, 32'h10);
        step(2);
        check("R7 low", {31'b0, status[4]}, 32'd1);
        pins[4] = 1'b1;
        step(4);
        do_read();
        check("R7 released", {31'b0, status[4]}, 32'd0);

        // R9 edge in the read cycle is kept
        check("R9 precondition", status, '0);
        pins[5] = 1'b1;
        step(2);
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        check("R9 kept", {31'b0, status[5]}, 32'd1);
        do_read();
        check("R9 then cleared", status, '0);

        // R10 masking and combined line
        cmd(3'd0, 32'h1);
        pins[6] = 1'b1;
        step(3);
        check("R10 masked recorded", {31'b0, status[6]}, 32'd1);
        check("R10 masked no irq", {31'b0, irq}, 32'd0);
        cmd(3'd0, 32'h40);
        check("R10 irq on", {31'b0, irq}, 32'd1);
        do_read();
        check("R10 irq after read", {31'b0, irq}, 32'd0);
        pins[6] = 1'b0;
        step(3);
        check("R10 irq again", {31'b0, irq}, 32'd1);
        cmd(3'd1, '1);
        check("R10 irq disabled", {31'b0, irq}, 32'd0);

        // R11 sticky without read
        step(10);
        check("R11 sticky", {31'b0, status[6]}, 32'd1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule